// File: doc/BRIEF.md
# Cross-Triggered Probe Capture Unit

This block is an on-chip capture unit. It watches a bundle of probe fields on its own clock. Each field has one match unit that either tests the field for equality with a programmed compare value or ignores it. The trigger condition is the AND of all match units. Once armed, the unit records every probe sample into a circular sample store. When the trigger fires, it keeps a programmable number of samples from before the trigger and fills the rest of the window with samples from after it. It then raises a completion flag and holds the window until it is armed again.

Several units are linked across clock domains. A unit that watches the bus master side fires a stretched trigger-out pulse when its address compare matches. A unit on another clock, such as the memory-controller clock, takes that pulse on its cross-trigger input. The pulse passes through a two-flop synchroniser and becomes the last probe field. Its match unit can therefore freeze the receiving unit's capture at the moment the master-side match happens. A unit built with the trigger-out generate option off drives that port low.

Configuration goes in through a write-only register port. Captured samples come out through a separate indexed readout port, oldest sample first.

Top module: `xcap_unit`

## Requirements
- R1: While reset is asserted, and until the first arm, the unit is neither busy nor complete, and `xtrig_out` is low.
- R2: Each match unit compares the low W bits of its field with its compare value when its enable bit is 1, and is always true when the enable bit is 0. A trigger needs every enabled match unit to be true in the same sample.
- R3: With only the 36-bit field (field 2) enabled and set to a bus address such as 0x0000F000, the capture triggers on the first eligible sample that carries that address.
- R4: After an arm, the unit ignores trigger matches until PRE samples have been stored. PRE is the value latched from the pre-trigger register at arm time. A match in the first PRE samples is ignored.
- R5: The captured window holds DEPTH samples: PRE samples before the trigger sample, the trigger sample, and DEPTH-PRE-1 samples after it. `cap_done` rises one clock after the last of these is stored. This holds for PRE=0 and PRE=DEPTH-1.
- R6: Readout index k returns the k-th oldest sample of the window, with window position PRE holding the trigger sample. `rd_sample` is registered one clock after `rd_idx`. The sample layout is {synchronised cross-trigger, probe}, with field 0 at bit 0 and the fields packed upward in field order.
- R7: `xtrig_in` passes through two flops before it is used. The level present at sample edge k is the level `xtrig_in` had at edge k-2. That level forms field 9 (1 bit), which is matchable and stored in sample bit 59.
- R8: On the trigger edge, `xtrig_out` goes high and stays high for STRETCH clocks.
- R9: After completion, further matches and cross-trigger pulses change neither the window nor the flags, and `xtrig_out` stays low. A new write of 1 to bit 0 of address 0x00 clears the completion flag and starts a fresh capture, which may use changed compare values.
- R10: The register map is as follows. Address 0x00 bit 0 = arm. Address 0x01 = pre-trigger count. 0x10+i = compare bits 31:0 of field i. 0x20+i = compare bits 63:32 of field i. 0x30+i bit 0 = enable of field i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of this unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe | input | 59 | Probe fields 0 to 8, packed from bit 0 |
| xtrig_in | input | 1 | Cross-trigger from another unit's clock domain |
| xtrig_out | output | 1 | Stretched trigger pulse for other units |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 32 | Register write data |
| rd_idx | input | 4 | Readout index, 0 = oldest sample |
| rd_sample | output | 60 | Registered readout sample |
| cap_busy | output | 1 | Armed and collecting samples |
| cap_done | output | 1 | Window complete |

## Verification
Probes are random, with matching values planted at chosen sample indices. This separates a trigger on a single address field from a trigger on an AND of fields. In the AND case, an address hit without the qualifier must not fire. A match planted inside the pre-trigger span must be skipped, and the two ends of the pre-trigger range (0 and DEPTH-1) move the trigger sample to the first and last window slots. A cross-trigger level raised at a known index checks the two-clock synchroniser delay and shows that the stored sample bit follows it. Post-completion traffic followed by a re-arm with new compare values shows that a finished window is frozen until the next arm.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [2:0] {
    CAP_IDLE,
    CAP_FILL,
    CAP_WAIT,
    CAP_POST,
    CAP_DONE
  } cap_state_e;

  // Width of field idx, one byte per field in the table, field 0 lowest.
  function automatic int unsigned field_w(input logic [127:0] tbl, input int unsigned idx);
    return 32'(tbl[idx*8 +: 8]);
  endfunction

  // Bit offset of field idx inside the packed sample.
  function automatic int unsigned field_off(input logic [127:0] tbl, input int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < idx; j++) acc += field_w(tbl, j);
    return acc;
  endfunction

  // Total packed width of the first n fields.
  function automatic int unsigned span_w(input logic [127:0] tbl, input int unsigned n);
    return field_off(tbl, n);
  endfunction

endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/trig_stretch.sv
module trig_stretch #(
  parameter int unsigned STRETCH = 4,
  localparam int unsigned CW = $clog2(STRETCH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic stretched
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q;

  always_comb begin
    cnt_d = cnt_q;
    if (pulse)              cnt_d = CW'(STRETCH);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= (cnt_d != '0);
    end
  end

  assign stretched = out_q;

  // R8: a rise of the output follows a trigger pulse
  assert_stretch_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(pulse));
  // R8: a pulse always drives the output high on the next cycle
  assert_stretch_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> out_q);
endmodule

// File: rtl/match_unit.sv
module match_unit #(
  parameter int unsigned W  = 1,
  parameter int unsigned CW = 64
) (
  input  logic [W-1:0]  field,
  input  logic [CW-1:0] cmp,
  input  logic          en,
  output logic          hit
);
  localparam logic [CW-1:0] MASK = (W >= CW) ? '1 : ((CW'(1) << W) - CW'(1));
  logic [CW-1:0] field_x;

  assign field_x = CW'(field);
  assign hit     = !en || (((field_x ^ cmp) & MASK) == '0);
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import cap_pkg::*;
#(
  parameter int unsigned SW    = 60,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] pre,
  input  logic          hit,
  input  logic [SW-1:0] sample,
  input  logic [AW-1:0] rd_idx,
  output logic [SW-1:0] rd_sample,
  output logic          fire,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e    state_q, state_d;
  logic [AW-1:0] wp_q, wp_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] start_q, start_d;
  logic [AW-1:0] pre_q, pre_d;
  logic          wr_en;
  logic [SW-1:0] store [DEPTH];
  logic [SW-1:0] rd_q;

  always_comb begin
    state_d = state_q;
    wp_d    = wp_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    pre_d   = pre_q;
    fire    = 1'b0;
    wr_en   = (state_q == CAP_FILL) || (state_q == CAP_WAIT) || (state_q == CAP_POST);
    if (wr_en) wp_d = wp_q + AW'(1);
    if (arm) begin
      pre_d   = pre;
      cnt_d   = '0;
      state_d = (pre == '0) ? CAP_WAIT : CAP_FILL;
    end else begin
      case (state_q)
        CAP_FILL: begin
          cnt_d = cnt_q + AW'(1);
          if (cnt_q == pre_q - AW'(1)) state_d = CAP_WAIT;
        end
        CAP_WAIT: begin
          if (hit) begin
            fire    = 1'b1;
            start_d = wp_q - pre_q;
            cnt_d   = LAST - pre_q;
            state_d = (pre_q == LAST) ? CAP_DONE : CAP_POST;
          end
        end
        CAP_POST: begin
          cnt_d = cnt_q - AW'(1);
          if (cnt_q == AW'(1)) state_d = CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      wp_q    <= '0;
      cnt_q   <= '0;
      start_q <= '0;
      pre_q   <= '0;
    end else begin
      state_q <= state_d;
      wp_q    <= wp_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      pre_q   <= pre_d;
    end
  end

  // Sample store: plain storage without reset.
  always_ff @(posedge clk) begin
    if (wr_en) store[wp_q] <= sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= store[start_q + rd_idx];
  end

  assign rd_sample = rd_q;
  assign busy      = wr_en;
  assign done      = (state_q == CAP_DONE);

  // R4: the pre-trigger fill never jumps straight to post-trigger storage
  assert_fill_no_post_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_FILL) |=> (state_q != CAP_POST));
  // R4: post-trigger storage is only entered from the waiting state
  assert_post_from_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_POST && $past(state_q) != CAP_POST) |-> ($past(state_q) == CAP_WAIT));
  // R9: a finished window stays finished until the next arm
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_DONE && !arm) |=> (state_q == CAP_DONE));
endmodule

// File: rtl/xcap_unit.sv
module xcap_unit
  import cap_pkg::*;
#(
  parameter int unsigned   NP           = 10,
  parameter logic [127:0]  FIELD_WIDTHS = {48'h0, 8'd1, 8'd1, 8'd1, 8'd1, 8'd16,
                                           8'd1, 8'd1, 8'd36, 8'd1, 8'd1},
  parameter int unsigned   DEPTH        = 16,
  parameter int unsigned   STRETCH      = 4,
  parameter bit            HAS_TRIG_OUT = 1'b1,
  localparam int unsigned  SW = span_w(FIELD_WIDTHS, NP),
  localparam int unsigned  PW = SW - 1,
  localparam int unsigned  AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] probe,
  input  logic          xtrig_in,
  output logic          xtrig_out,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic [AW-1:0] rd_idx,
  output logic [SW-1:0] rd_sample,
  output logic          cap_busy,
  output logic          cap_done
);
  localparam logic [7:0] A_ARM = 8'h00;
  localparam logic [7:0] A_PRE = 8'h01;
  localparam logic [7:0] A_CLO = 8'h10;
  localparam logic [7:0] A_CHI = 8'h20;
  localparam logic [7:0] A_EN  = 8'h30;

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          xsync;
  logic [SW-1:0] sample_vec;
  logic [63:0]   cmp_q [NP];
  logic [NP-1:0] en_q;
  logic [AW-1:0] pre_q;
  logic [NP-1:0] field_hit;
  logic          trig_hit;
  logic          arm;
  logic          fire;

  // Reset asserted at once, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int i = 0; i < NP; i++) cmp_q[i] <= '0;
      en_q  <= '0;
      pre_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_PRE) pre_q <= cfg_wdata[AW-1:0];
      for (int i = 0; i < NP; i++) begin
        if (cfg_addr == A_CLO + 8'(i)) cmp_q[i][31:0]  <= cfg_wdata;
        if (cfg_addr == A_CHI + 8'(i)) cmp_q[i][63:32] <= cfg_wdata;
        if (cfg_addr == A_EN  + 8'(i)) en_q[i]         <= cfg_wdata[0];
      end
    end
  end

  assign arm = cfg_we && (cfg_addr == A_ARM) && cfg_wdata[0];

  xtrig_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .async_in (xtrig_in),
    .sync_out (xsync)
  );

  assign sample_vec = {xsync, probe};

  for (genvar i = 0; i < NP; i++) begin : g_field
    localparam int unsigned WI  = field_w(FIELD_WIDTHS, i);
    localparam int unsigned OFF = field_off(FIELD_WIDTHS, i);
    match_unit #(.W(WI), .CW(64)) u_match (
      .field (sample_vec[OFF +: WI]),
      .cmp   (cmp_q[i]),
      .en    (en_q[i]),
      .hit   (field_hit[i])
    );
  end

  assign trig_hit = &field_hit;

  capture_ctrl #(.SW(SW), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .arm       (arm),
    .pre       (pre_q),
    .hit       (trig_hit),
    .sample    (sample_vec),
    .rd_idx    (rd_idx),
    .rd_sample (rd_sample),
    .fire      (fire),
    .busy      (cap_busy),
    .done      (cap_done)
  );

  if (HAS_TRIG_OUT) begin : g_tout
    trig_stretch #(.STRETCH(STRETCH)) u_stretch (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .pulse     (fire),
      .stretched (xtrig_out)
    );
  end else begin : g_no_tout
    assign xtrig_out = 1'b0;
  end

  // R2: a trigger is only taken when every enabled field matches
  assert_fire_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    fire |-> trig_hit);
  // R5: completion never coincides with collecting
  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    cap_done |-> !cap_busy);
endmodule

// File: tb/xcap_unit_tb.sv
module xcap_unit_tb;
  localparam int DEPTH = 16;
  localparam int PW    = 59;
  localparam int SW    = 60;
  localparam int STR   = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [PW-1:0] probe;
  logic          xtrig_in;
  logic          xtrig_out;
  logic          cfg_we;
  logic [7:0]    cfg_addr;
  logic [31:0]   cfg_wdata;
  logic [3:0]    rd_idx;
  logic [SW-1:0] rd_sample;
  logic          cap_busy, cap_done;

  xcap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .probe(probe), .xtrig_in(xtrig_in), .xtrig_out(xtrig_out),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_idx(rd_idx),
    .rd_sample(rd_sample), .cap_busy(cap_busy), .cap_done(cap_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [PW-1:0] stim [64];
  bit            xin  [64];
  logic [63:0]   b_cmp [10];
  bit            b_en  [10];
  int            b_pre;
  int            fw [10] = '{1, 1, 36, 1, 1, 16, 1, 1, 1, 1};

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] samp(input int k);
    logic xs;
    xs = (k >= 2) ? xin[k-2] : 1'b0;
    return {xs, stim[k]};
  endfunction

  function automatic bit hit(input int k);
    logic [63:0] s, f, m;
    int off;
    s = 64'(samp(k));
    off = 0;
    for (int i = 0; i < 10; i++) begin
      m = (64'd1 << fw[i]) - 64'd1;
      f = (s >> off) & m;
      if (b_en[i] && (f != (b_cmp[i] & m))) return 1'b0;
      off += fw[i];
    end
    return 1'b1;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_field(input int i, input logic [63:0] c, input bit en);
    wr(8'h10 + 8'(i), c[31:0]);
    wr(8'h20 + 8'(i), c[63:32]);
    wr(8'h30 + 8'(i), {31'd0, en});
    b_cmp[i] = c;
    b_en[i]  = en;
  endtask

  task automatic set_pre(input int p);
    wr(8'h01, 32'(p));
    b_pre = p;
  endtask

  task automatic fill_random();
    for (int k = 0; k < 64; k++) begin
      stim[k] = PW'({$urandom(), $urandom()});
      xin[k]  = 1'b0;
    end
  endtask

  task automatic capture(input string req, input int maxk, output int t);
    int n;
    bit xo_ok;
    t = -1;
    for (int k = b_pre; k < maxk; k++) if (t < 0 && hit(k)) t = k;
    n = (t >= 0) ? t - b_pre + DEPTH + 2 : maxk;
    wr(8'h00, 32'd1);
    xo_ok = 1'b1;
    for (int k = 0; k < n; k++) begin
      probe = stim[k];
      xtrig_in = xin[k];
      @(negedge clk);
      if (xtrig_out !== ((t >= 0) && (k >= t) && (k < t + STR))) xo_ok = 1'b0;
    end
    check({req, " R8"}, "xtrig_out window", 64'(xo_ok), 64'd1);
    check({req, " R5"}, "cap_done", 64'(cap_done), 64'(t >= 0));
    check({req, " R5"}, "cap_busy", 64'(cap_busy), 64'(t < 0));
  endtask

  task automatic readout(input string req, input int t);
    for (int k = 0; k < DEPTH; k++) begin
      rd_idx = 4'(k);
      @(negedge clk);
      check({req, " R6"}, $sformatf("sample %0d", k), 64'(rd_sample), 64'(samp(t - b_pre + k)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd7));
    rst_n = 1'b0; probe = '0; xtrig_in = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; rd_idx = '0;
    for (int i = 0; i < 10; i++) begin b_cmp[i] = '0; b_en[i] = 1'b0; end
    b_pre = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy in reset", 64'(cap_busy), 64'd0);
    check("R1", "done in reset", 64'(cap_done), 64'd0);
    check("R1", "xtrig_out in reset", 64'(xtrig_out), 64'd0);
    check("R1", "rd_sample in reset", 64'(rd_sample), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "busy after reset", 64'(cap_busy), 64'd0);
    check("R1", "done after reset", 64'(cap_done), 64'd0);

    // R3/R4: address match 0x0000F000, pre 4, early hit at 1 is ignored
    set_field(2, 64'h0000F000, 1'b1);
    set_pre(4);
    fill_random();
    stim[1][37:2] = 36'h0000F000;
    stim[9][37:2] = 36'h0000F000;
    capture("R3 R4", 40, t);
    check("R4", "trigger index model", 64'(t), 64'd9);
    readout("R3 R4 R5", t);

    // R2: AND of address 0x0000F100 and field 6 = 1
    set_field(2, 64'h0000F100, 1'b1);
    set_field(6, 64'h1, 1'b1);
    set_pre(2);
    fill_random();
    stim[5][37:2] = 36'h0000F100; stim[5][56] = 1'b0;
    stim[11][37:2] = 36'h0000F100; stim[11][56] = 1'b1;
    capture("R2", 40, t);
    check("R2", "trigger index model", 64'(t), 64'd11);
    readout("R2", t);

    // R5: pre 0, trigger sample is the oldest
    set_field(2, 64'h0, 1'b0);
    set_field(6, 64'h0, 1'b0);
    set_field(5, 64'hBEEF, 1'b1);
    set_pre(0);
    fill_random();
    stim[0][55:40] = 16'hBEEF;
    capture("R5 pre0", 40, t);
    readout("R5 pre0", t);

    // R5: pre DEPTH-1, trigger sample is the newest
    set_pre(15);
    fill_random();
    for (int k = 0; k < 64; k++) if (stim[k][55:40] == 16'hBEEF) stim[k][40] = ~stim[k][40];
    stim[3][55:40] = 16'hBEEF;
    stim[20][55:40] = 16'hBEEF;
    capture("R5 pre15", 40, t);
    check("R5", "trigger index model", 64'(t), 64'd20);
    readout("R5 pre15", t);

    // R7: cross-trigger on field 9 through the synchroniser
    set_field(5, 64'h0, 1'b0);
    set_field(9, 64'h1, 1'b1);
    set_pre(2);
    fill_random();
    for (int k = 6; k < 64; k++) xin[k] = 1'b1;
    capture("R7", 40, t);
    check("R7", "trigger index model", 64'(t), 64'd8);
    readout("R7", t);

    // R9: no re-arm means window and flags stay frozen
    begin
      bit xo_ok;
      xo_ok = 1'b1;
      for (int k = 0; k < 20; k++) begin
        probe = PW'({$urandom(), $urandom()});
        xtrig_in = 1'b1;
        @(negedge clk);
        if (xtrig_out !== 1'b0) xo_ok = 1'b0;
      end
      check("R9", "xtrig_out quiet after done", 64'(xo_ok), 64'd1);
      check("R9", "done held", 64'(cap_done), 64'd1);
      check("R9", "busy held low", 64'(cap_busy), 64'd0);
      readout("R9 frozen", t);
    end

    // R9/R10: change compare value and re-arm
    xtrig_in = 1'b0;
    set_field(9, 64'h0, 1'b0);
    set_field(2, 64'h0000F100, 1'b1);
    set_pre(3);
    fill_random();
    stim[7][37:2] = 36'h0000F100;
    capture("R9 R10 rearm", 40, t);
    check("R9", "trigger index model", 64'(t), 64'd7);
    readout("R9 R10 rearm", t);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule